// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The switch moves byte-wide time slots between eight incoming and eight outgoing time-division links. Each link carries 32 slots per frame, so any of 256 output slots can take its byte from any of 256 input slots. One slot period is marked by a single-cycle `slot_tick`. On that cycle the block takes one byte per input link for the current slot and produces one byte per output link for the same slot. An internal slot counter, visible as `cur_slot`, tells the upstream framer which slot to present next. Serialisation, clock recovery and test-pattern generation belong to neighbouring blocks.

A 256-entry connection table selects the source for each output slot. It is written one entry at a time through a small write port. Each entry carries a valid flag and a delay-mode flag. In minimum-delay mode a byte leaves as soon as it can. In frame-preserving mode every byte of an input frame leaves within one output frame, at a fixed offset. A loopback flag feeds the output byte back in place of the incoming byte with the same link and slot numbers. Received data sits in three rotating frame banks.

Table writes go to a shadow copy. A two-state controller tracks whether the shadow differs from the live table. In `CM_SETTLED` the tables agree. A write moves the controller to `CM_PENDING`. At a frame boundary the shadow is copied to the live table, and the controller returns to `CM_SETTLED`. If a write lands on that same boundary cycle, the controller stays in `CM_PENDING` instead.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `cur_slot` is 0, `out_valid` is 0 and `out_bytes` is 0. Every table entry is invalid and all stored data bytes are 0.
- R2: A `slot_tick` while `cur_slot` = s gives `out_valid` = 1 and `out_slot` = s on the next cycle, with `out_valid` 0 otherwise. `cur_slot` advances to s+1 modulo 32 on a tick and holds without one. `out_bytes` changes only after a tick.
- R3: In minimum-delay mode, a source slot x lower than the output slot y gives the byte taken in the same frame, a delay of y - x slots.
- R4: In minimum-delay mode, a source slot x equal to or above y gives the byte of the previous frame, a delay of 32 - (x - y) slots (32 when x = y).
- R5: In frame-preserving mode, the output byte is the one taken two frames earlier at the source, a delay of (32 - x) + 32 + y slots, between 33 and 95.
- R6: An output slot whose entry is invalid emits 0xFF. The loop and mode flags of an invalid entry have no effect.
- R7: When the entry for output (link i, slot j) is valid with its loop flag set, the byte emitted there is stored as input (link i, slot j) in place of the byte on `in_bytes`. The output still carries that byte.
- R8: A loop flag affects only its own entry's link and slot. An input that feeds a looped output, without itself being looped, is stored unchanged.
- R9: A table write becomes live at the first frame boundary after it, which is the tick with `cur_slot` = 31. A write in the same cycle as a boundary tick becomes live one frame later.
- R10: The table address is {output link[7:5], output slot[4:0]}, and the entry word is {valid[10], mode[9] (1 = frame-preserving), loop[8], source link[7:5], source slot[4:0]}. Input and output link k occupy bits [8k+7:8k] of `in_bytes` and `out_bytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-cycle strobe marking a slot period |
| in_bytes | input | 64 | One byte per input link for slot `cur_slot` |
| cur_slot | output | 5 | Slot taken and produced at the next tick |
| cfg_we | input | 1 | Connection table write strobe |
| cfg_addr | input | 8 | Output link and slot of the entry |
| cfg_word | input | 11 | Entry contents |
| out_valid | output | 1 | Output bytes were updated by the last tick |
| out_slot | output | 5 | Slot number of `out_bytes` |
| out_bytes | output | 64 | One byte per output link |

## Verification
The checks assume `slot_tick` is a single-cycle pulse that is never held high two cycles in a row. They also assume `in_bytes` is stable on the tick cycle and that table writes are single-cycle strobes. The stimulus drives each tick for exactly one cycle, separated by one to three idle cycles. It changes inputs only on falling edges, and it issues writes both between ticks and on a frame-boundary tick. A reference history of three frames, kept in the stimulus, predicts every output byte, including bytes replaced by loopback.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
    localparam int NBANK = 3;
    localparam int BANK_W = 2;

    typedef enum logic {
        CM_SETTLED = 1'b0,
        CM_PENDING = 1'b1
    } cm_state_e;

    function automatic logic [BANK_W-1:0] bank_back(input logic [BANK_W-1:0] cur, input int unsigned n);
        int unsigned v;
        v = (int'(cur) + NBANK - n) % NBANK;
        return BANK_W'(v);
    endfunction
endpackage

// File: rtl/tsi_slot_timer.sv
`timescale 1ns/1ps
module tsi_slot_timer #(
    parameter int NSLOT = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    output logic [$clog2(NSLOT)-1:0]   slot,
    output logic [tsi_pkg::BANK_W-1:0] bank,
    output logic                       frame_end
);
    import tsi_pkg::*;
    localparam int SW = $clog2(NSLOT);

    logic [SW-1:0]     slot_q;
    logic [BANK_W-1:0] bank_q;

    assign frame_end = tick && (slot_q == SW'(NSLOT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            bank_q <= '0;
        end else if (tick) begin
            slot_q <= (slot_q == SW'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
            if (frame_end) begin
                bank_q <= (bank_q == BANK_W'(NBANK - 1)) ? '0 : bank_q + 1'b1;
            end
        end
    end

    assign slot = slot_q;
    assign bank = bank_q;
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem #(
    parameter int NLINK = 8,
    parameter int NSLOT = 32
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  wr_en,
    input  logic [$clog2(NLINK)+$clog2(NSLOT)-1:0]                wr_addr,
    input  logic [3+$clog2(NLINK)+$clog2(NSLOT)-1:0]              wr_word,
    input  logic                                                  frame_end,
    input  logic [$clog2(NSLOT)-1:0]                              rd_slot,
    output logic [NLINK*(3+$clog2(NLINK)+$clog2(NSLOT))-1:0]      rd_words
);
    import tsi_pkg::*;
    localparam int LW   = $clog2(NLINK);
    localparam int SW   = $clog2(NSLOT);
    localparam int AW   = LW + SW;
    localparam int CW   = 3 + AW;
    localparam int NENT = NLINK * NSLOT;

    cm_state_e state_q, state_d;
    logic      commit;

    logic [CW-1:0] shadow_q [NENT];
    logic [CW-1:0] live_q   [NENT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_SETTLED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_SETTLED: if (wr_en) state_d = CM_PENDING;
            CM_PENDING: if (frame_end && !wr_en) state_d = CM_SETTLED;
            default:    state_d = CM_SETTLED;
        endcase
    end

    // outputs of the controller
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            CM_SETTLED: commit = 1'b0;
            CM_PENDING: commit = frame_end;
            default:    commit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) shadow_q[e] <= '0;
        end else if (wr_en) begin
            shadow_q[wr_addr] <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) live_q[e] <= '0;
        end else if (commit) begin
            for (int e = 0; e < NENT; e++) live_q[e] <= shadow_q[e];
        end
    end

    for (genvar o = 0; o < NLINK; o++) begin : g_rd
        assign rd_words[o*CW +: CW] = live_q[{LW'(o), rd_slot}];
    end
endmodule

// File: rtl/tsi_data_store.sv
`timescale 1ns/1ps
module tsi_data_store #(
    parameter int NLINK = 8,
    parameter int NSLOT = 32,
    parameter int DW    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [tsi_pkg::BANK_W-1:0]            wr_bank,
    input  logic [$clog2(NSLOT)-1:0]              wr_slot,
    input  logic [NLINK*DW-1:0]                   wr_data,
    input  logic [NLINK*tsi_pkg::BANK_W-1:0]      rd_bank,
    input  logic [NLINK*$clog2(NLINK)-1:0]        rd_link,
    input  logic [NLINK*$clog2(NSLOT)-1:0]        rd_slot,
    output logic [NLINK*DW-1:0]                   rd_data
);
    import tsi_pkg::*;
    localparam int LW = $clog2(NLINK);
    localparam int SW = $clog2(NSLOT);

    logic [DW-1:0] mem_q [NBANK][NLINK][NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
                for (int l = 0; l < NLINK; l++)
                    for (int s = 0; s < NSLOT; s++)
                        mem_q[b][l][s] <= '0;
        end else if (we) begin
            for (int l = 0; l < NLINK; l++)
                mem_q[wr_bank][l][wr_slot] <= wr_data[l*DW +: DW];
        end
    end

    for (genvar o = 0; o < NLINK; o++) begin : g_rd
        assign rd_data[o*DW +: DW] =
            mem_q[rd_bank[o*BANK_W +: BANK_W]][rd_link[o*LW +: LW]][rd_slot[o*SW +: SW]];
    end
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch #(
    parameter int NLINK = 8,
    parameter int NSLOT = 32,
    parameter int DW    = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        slot_tick,
    input  logic [NLINK*DW-1:0]                         in_bytes,
    output logic [$clog2(NSLOT)-1:0]                    cur_slot,
    input  logic                                        cfg_we,
    input  logic [$clog2(NLINK)+$clog2(NSLOT)-1:0]      cfg_addr,
    input  logic [3+$clog2(NLINK)+$clog2(NSLOT)-1:0]    cfg_word,
    output logic                                        out_valid,
    output logic [$clog2(NSLOT)-1:0]                    out_slot,
    output logic [NLINK*DW-1:0]                         out_bytes
);
    import tsi_pkg::*;
    localparam int LW = $clog2(NLINK);
    localparam int SW = $clog2(NSLOT);
    localparam int AW = LW + SW;
    localparam int CW = 3 + AW;
    localparam int F_VALID = CW - 1;
    localparam int F_MODE  = CW - 2;
    localparam int F_LOOP  = CW - 3;

    logic [SW-1:0]     slot;
    logic [BANK_W-1:0] bank, bank_prev, bank_prev2;
    logic              frame_end;

    logic [NLINK*CW-1:0]     ent_words;
    logic [NLINK*BANK_W-1:0] rd_bank;
    logic [NLINK*LW-1:0]     rd_link;
    logic [NLINK*SW-1:0]     rd_slot;
    logic [NLINK*DW-1:0]     rd_data;
    logic [NLINK*DW-1:0]     sel_bytes;
    logic [NLINK*DW-1:0]     store_bytes;

    tsi_slot_timer #(.NSLOT(NSLOT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (slot_tick),
        .slot      (slot),
        .bank      (bank),
        .frame_end (frame_end)
    );

    tsi_conn_mem #(.NLINK(NLINK), .NSLOT(NSLOT)) u_cmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_word   (cfg_word),
        .frame_end (frame_end),
        .rd_slot   (slot),
        .rd_words  (ent_words)
    );

    assign bank_prev  = bank_back(bank, 1);
    assign bank_prev2 = bank_back(bank, 2);

    for (genvar o = 0; o < NLINK; o++) begin : g_path
        logic [CW-1:0] ent;
        logic          e_valid, e_mode, e_loop;
        logic [LW-1:0] e_link;
        logic [SW-1:0] e_slot;
        logic [DW-1:0] picked;

        assign ent     = ent_words[o*CW +: CW];
        assign e_valid = ent[F_VALID];
        assign e_mode  = ent[F_MODE];
        assign e_loop  = ent[F_LOOP];
        assign e_link  = ent[SW +: LW];
        assign e_slot  = ent[SW-1:0];

        // frame-preserving reads two frames back; otherwise the newest copy already taken
        always_comb begin
            if (e_mode)              rd_bank[o*BANK_W +: BANK_W] = bank_prev2;
            else if (e_slot < slot)  rd_bank[o*BANK_W +: BANK_W] = bank;
            else                     rd_bank[o*BANK_W +: BANK_W] = bank_prev;
        end

        assign rd_link[o*LW +: LW] = e_link;
        assign rd_slot[o*SW +: SW] = e_slot;

        assign picked = e_valid ? rd_data[o*DW +: DW] : {DW{1'b1}};
        assign sel_bytes[o*DW +: DW] = picked;

        // loopback replaces the incoming byte of the same link and slot
        assign store_bytes[o*DW +: DW] = (e_valid && e_loop) ? picked : in_bytes[o*DW +: DW];
    end

    tsi_data_store #(.NLINK(NLINK), .NSLOT(NSLOT), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (slot_tick),
        .wr_bank (bank),
        .wr_slot (slot),
        .wr_data (store_bytes),
        .rd_bank (rd_bank),
        .rd_link (rd_link),
        .rd_slot (rd_slot),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_bytes <= '0;
        end else begin
            out_valid <= slot_tick;
            if (slot_tick) begin
                out_slot  <= slot;
                out_bytes <= sel_bytes;
            end
        end
    end

    assign cur_slot = slot;
endmodule

// File: rtl/tsi_switch_chk.sv
`timescale 1ns/1ps
module tsi_switch_chk #(
    parameter int NLINK = 8,
    parameter int NSLOT = 32,
    parameter int DW    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      slot_tick,
    input logic [$clog2(NSLOT)-1:0]  cur_slot,
    input logic                      out_valid,
    input logic [$clog2(NSLOT)-1:0]  out_slot,
    input logic [NLINK*DW-1:0]       out_bytes
);
    localparam int SW = $clog2(NSLOT);

    a_r2_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> out_valid);

    a_r2_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> !out_valid);

    a_r2_slot_echo: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> out_slot == $past(cur_slot));

    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && cur_slot == SW'(NSLOT - 1)) |=> cur_slot == '0);

    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && cur_slot != SW'(NSLOT - 1)) |=> cur_slot == $past(cur_slot) + 1'b1);

    a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(cur_slot));

    a_r2_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(out_bytes));
endmodule

bind tsi_switch tsi_switch_chk #(.NLINK(NLINK), .NSLOT(NSLOT), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .cur_slot  (cur_slot),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .out_bytes (out_bytes)
);

// File: tb/tsi_switch_tb_top.sv
`timescale 1ns/1ps
module tsi_switch_tb_top;
    localparam int NL = 8;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_tick = 1'b0;
    logic [63:0] in_bytes = '0;
    logic [4:0]  cur_slot;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [10:0] cfg_word = '0;
    logic        out_valid;
    logic [4:0]  out_slot;
    logic [63:0] out_bytes;

    always #2.5 clk = ~clk;

    tsi_switch dut_i (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .in_bytes(in_bytes),
        .cur_slot(cur_slot), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_word(cfg_word),
        .out_valid(out_valid), .out_slot(out_slot), .out_bytes(out_bytes)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic [7:0]  hist    [3][NL][NS];
    bit          lp_mark [3][NL][NS];
    logic [10:0] shadow_m[256];
    logic [10:0] live_m  [256];
    int          frm = 0;
    int          sm  = 0;
    int unsigned seed = 32'h1234_5678;
    string       phase = "init";

    // scoreboard queues
    logic [7:0] eb_q[$];
    string      tg_q[$];
    int         es_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s got=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic [10:0] map_for(input int o, input int y);
        case (o)
            0: return {3'b100, 3'd3, 5'((y * 7 + 1) % NS)};
            1: return {3'b110, 3'd5, 5'(31 - y)};
            2: return {3'b100, 3'd2, 5'(y)};
            3: return {3'b011, 3'd1, 5'(y)};        // invalid with loop and mode set
            4: return {3'b101, 3'd7, 5'((y + 3) % NS)};
            5: return {3'b100, 3'd4, 5'(y)};
            6: return {3'b110, 3'd6, 5'd0};
            default: return {3'b100, 3'd5, 5'(y)};
        endcase
    endfunction

    function automatic logic [63:0] next_word();
        logic [63:0] w;
        seed = seed * 32'd1103515245 + 32'd12345;
        w[31:0] = seed;
        seed = seed * 32'd1103515245 + 32'd12345;
        w[63:32] = seed;
        return w;
    endfunction

    task automatic do_tick(input logic [63:0] w, input bit with_cfg,
                           input logic [7:0] ca, input logic [10:0] cw);
        logic [7:0] st[NL];
        bit         lpm[NL];
        @(negedge clk);
        check(cur_slot == 5'(sm), "R2", "cur_slot before tick", 64'(cur_slot), 64'(sm));
        in_bytes  = w;
        slot_tick = 1'b1;
        if (with_cfg) begin
            cfg_we = 1'b1; cfg_addr = ca; cfg_word = cw;
        end
        for (int o = 0; o < NL; o++) begin
            logic [10:0] e;
            logic [7:0]  ex;
            string       tag;
            int          tl, tx, b;
            e = live_m[o * NS + sm];
            if (!e[10]) begin
                ex = 8'hFF; tag = "R6";
            end else begin
                tl = int'(e[7:5]); tx = int'(e[4:0]);
                if (e[9])          begin b = (frm + 1) % 3; tag = "R5"; end
                else if (tx < sm)  begin b = frm % 3;       tag = "R3"; end
                else               begin b = (frm + 2) % 3; tag = "R4"; end
                ex = hist[b][tl][tx];
                if (lp_mark[b][tl][tx]) tag = "R7";
                else if (tl == 5 && !e[9]) tag = "R8";
            end
            st[o]  = (e[10] && e[8]) ? ex : w[o*8 +: 8];
            lpm[o] = e[10] && e[8];
            eb_q.push_back(ex);
            tg_q.push_back({tag, " [", phase, "]"});
        end
        es_q.push_back(sm);
        @(negedge clk);
        slot_tick = 1'b0;
        cfg_we    = 1'b0;
        for (int l = 0; l < NL; l++) begin
            hist[frm % 3][l][sm]    = st[l];
            lp_mark[frm % 3][l][sm] = lpm[l];
        end
        if (sm == NS - 1) begin
            for (int e = 0; e < 256; e++) live_m[e] = shadow_m[e];
            frm++;
            sm = 0;
        end else begin
            sm++;
        end
        if (with_cfg) shadow_m[ca] = cw;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [10:0] wd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_word = wd;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_m[a] = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (es_q.size() == 0) begin
                check(1'b0, "R2", "output without pending tick", 64'(out_slot), 64'd0);
            end else begin
                int s;
                s = es_q.pop_front();
                check(out_slot == 5'(s), "R2", "out_slot", 64'(out_slot), 64'(s));
                for (int o = 0; o < NL; o++) begin
                    logic [7:0] eb;
                    string      tg;
                    eb = eb_q.pop_front();
                    tg = tg_q.pop_front();
                    check(out_bytes[o*8 +: 8] == eb, tg,
                          $sformatf("link %0d slot %0d", o, s),
                          64'(out_bytes[o*8 +: 8]), 64'(eb));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 3; b++)
            for (int l = 0; l < NL; l++)
                for (int s = 0; s < NS; s++) begin
                    hist[b][l][s] = '0; lp_mark[b][l][s] = 1'b0;
                end
        for (int e = 0; e < 256; e++) begin shadow_m[e] = '0; live_m[e] = '0; end

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(cur_slot == 5'd0, "R1", "cur_slot after reset", 64'(cur_slot), 64'd0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(out_bytes == 64'd0, "R1", "out_bytes after reset", out_bytes, 64'd0);

        // R10 table layout: address {link, slot}, word {valid, mode, loop, link, slot}
        phase = "R10 load";
        for (int o = 0; o < NL; o++)
            for (int y = 0; y < NS; y++)
                cfg_write(8'(o * NS + y), map_for(o, y));

        // frame 0 still runs on the empty table (R9), later frames switch (R3..R8)
        phase = "main";
        for (int k = 0; k < 6 * NS; k++) begin
            do_tick(next_word(), 1'b0, '0, '0);
            idle(k % 3);
        end

        // R9 mid-frame write waits for the boundary
        phase = "R9 mid-frame";
        for (int k = 0; k < 10; k++) do_tick(next_word(), 1'b0, '0, '0);
        cfg_write(8'(0 * NS + 20), {3'b100, 3'd6, 5'd20});
        cfg_write(8'(3 * NS + 25), {3'b110, 3'd0, 5'd2});
        while (sm != NS - 1) do_tick(next_word(), 1'b0, '0, '0);
        // R9 write on the boundary tick is deferred one more frame
        phase = "R9 boundary";
        do_tick(next_word(), 1'b1, 8'(2 * NS + 4), 11'd0);
        for (int k = 0; k < 3 * NS; k++) do_tick(next_word(), 1'b0, '0, '0);

        idle(4);
        check(es_q.size() == 0, "R2", "outstanding ticks without output",
              64'(es_q.size()), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule